// File: doc/BRIEF.md
# Free-Running Timer with Compare Match

A 16-bit up-counter that advances once per count tick. The tick comes either from an internal single-cycle strobe or from rising edges of an external count clock that is not related to the system clock. A compare register is checked against the count. A set of sticky status flags records overflows and compare matches. A control bit makes the counter return to zero after a match. Another control bit splits the counter into two 8-bit halves. Each half is compared against its own byte of the compare register and has its own flags. In split mode the high half either counts on every tick or is carried from the low half.

A match is recorded on the tick that moves the count off the matching value, not in the cycle where the count first reaches it. Software loads the counter, the compare and the control registers through a simple write port. It clears flags by writing zeros to them. All register contents are visible on output ports. A module-stop input freezes the whole block.

Top module: `match_timer`

## Requirements
- R1: After reset the count is 0x0000, the compare value is 0xFFFF, and the control and status registers are 0.
- R2: With the internal source selected (control bit 3 = 0), each cycle with `intTick` high advances the count by exactly one. A write to address 0 loads the count, and this load wins over a tick in the same cycle. Address 1 is the compare register, address 2 the control register and address 3 the status register.
- R3: In 16-bit mode, a tick while the count is 0xFFFF makes the count 0x0000 and sets status bit 0.
- R4: In 16-bit mode, status bit 2 is set by the tick that moves the count away from a value equal to the compare register. No flag is set in the cycle when the count first reaches that value, or while it rests there.
- R5: With control bit 0 set, the tick that leaves a matching count loads 0 instead of count+1.
- R6: In split mode (control bit 1 set), the low byte is compared with compare bits 7:0 and the high byte with bits 15:8. A low-byte match sets status bit 3 and a high-byte match sets status bit 2. The low byte leaving 0xFF sets status bit 1 and the high byte leaving 0xFF sets status bit 0. With control bit 0 set, each half clears on its own match.
- R7: In split mode with control bit 2 clear, both bytes advance on every tick. With control bit 2 set, the high byte advances only on the tick where the low byte leaves 0xFF.
- R8: Status flags are sticky. A write to address 3 clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A flag set in the same cycle as such a write stays set.
- R9: With control bit 3 set, each rising edge of `extClk` advances the count once, within four clock cycles. `intTick` is then ignored.
- R10: While `stopReq` is high, the count does not advance, writes are ignored and all registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stopReq | input | 1 | Freezes counting and register writes |
| intTick | input | 1 | Internal count-enable strobe |
| extClk | input | 1 | Asynchronous external count clock |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 count, 1 compare, 2 control, 3 status |
| wrData | input | 16 | Write data |
| cntOut | output | 16 | Current count |
| cmpOut | output | 16 | Compare register |
| ctrlOut | output | 4 | Control: bit0 clear-on-match, bit1 split, bit2 cascade, bit3 external source |
| statusOut | output | 4 | Flags: bit0 high/16-bit overflow, bit1 low overflow, bit2 high/16-bit match, bit3 low match |

## Verification
The main counting path is driven with an alternating pattern of tick and idle cycles around the compare value. This separates a flag raised on arrival at the match from one raised on departure. It also shows that the count holds steady when no tick arrives. Wrap-around is tested at 0xFFFF and at each byte boundary. Split mode is run both with and without carry between the halves, so that independent counting can be told apart from cascaded counting. The flag-clear write is issued in the same cycle as a match, to show that the set takes priority. The external clock is held high across many cycles, to show that one edge gives exactly one count.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int CTRL_W = 4;
  localparam int FLAG_W = 4;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int C_CLR   = 0;
  localparam int C_SPLIT = 1;
  localparam int C_CASC  = 2;
  localparam int C_EXT   = 3;

  localparam int F_OVF_HI = 0;
  localparam int F_OVF_LO = 1;
  localparam int F_MAT_HI = 2;
  localparam int F_MAT_LO = 3;

  typedef struct packed {
    logic              incLo;
    logic              incHi;
    logic              zeroLo;
    logic              zeroHi;
    logic [FLAG_W-1:0] setFlag;
  } tmrStrobe_t;
endpackage

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import match_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stopReq,
  input  logic              intTick,
  input  logic              extClk,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp,
  input  logic [CTRL_W-1:0] ctrl,
  output tmrStrobe_t        strobe
);
  localparam int HALF = CNT_W / 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  always_ff @(posedge clk) begin
    if (!rst_n) syncQ[0] <= 1'b0;
    else        syncQ[0] <= extClk;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rst_n) syncQ[s] <= 1'b0;
      else        syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prevQ <= 1'b0;
    else        prevQ <= syncQ[SYNC_STAGES-1];
  end

  logic extEdge, tick, hiTick;
  logic [HALF-1:0] lo, hi;
  logic loMax, hiMax, matchFull, matchLo, matchHi;

  assign extEdge   = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign tick      = ~stopReq & (ctrl[C_EXT] ? extEdge : intTick);
  assign lo        = cnt[HALF-1:0];
  assign hi        = cnt[CNT_W-1:HALF];
  assign loMax     = &lo;
  assign hiMax     = &hi;
  assign matchFull = (cnt == cmp);
  assign matchLo   = (lo == cmp[HALF-1:0]);
  assign matchHi   = (hi == cmp[CNT_W-1:HALF]);
  assign hiTick    = ctrl[C_CASC] ? (tick & loMax) : tick;

  always_comb begin
    strobe = '0;
    strobe.incLo = tick;
    if (!ctrl[C_SPLIT]) begin
      strobe.incHi             = tick & loMax;
      strobe.zeroLo            = tick & matchFull & ctrl[C_CLR];
      strobe.zeroHi            = tick & matchFull & ctrl[C_CLR];
      strobe.setFlag[F_OVF_HI] = tick & loMax & hiMax;
      strobe.setFlag[F_MAT_HI] = tick & matchFull;
    end else begin
      strobe.incHi             = hiTick;
      strobe.zeroLo            = tick & matchLo & ctrl[C_CLR];
      strobe.zeroHi            = hiTick & matchHi & ctrl[C_CLR];
      strobe.setFlag[F_OVF_LO] = tick & loMax;
      strobe.setFlag[F_OVF_HI] = hiTick & hiMax;
      strobe.setFlag[F_MAT_LO] = tick & matchLo;
      strobe.setFlag[F_MAT_HI] = hiTick & matchHi;
    end
  end
endmodule

// File: rtl/match_timer_dp.sv
module match_timer_dp
  import match_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stopReq,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  tmrStrobe_t        strobe,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cmp,
  output logic [CTRL_W-1:0] ctrl,
  output logic [FLAG_W-1:0] status
);
  localparam int HALF = CNT_W / 2;

  logic wrOk;
  assign wrOk = wrEn & ~stopReq;

  logic [HALF-1:0] halfQ [2];
  logic [1:0] incV, zeroV;
  assign incV  = {strobe.incHi, strobe.incLo};
  assign zeroV = {strobe.zeroHi, strobe.zeroLo};

  for (genvar h = 0; h < 2; h++) begin : gHalf
    always_ff @(posedge clk) begin
      if (!rst_n)
        halfQ[h] <= '0;
      else if (wrOk && wrAddr == ADDR_CNT)
        halfQ[h] <= wrData[h*HALF +: HALF];
      else if (zeroV[h])
        halfQ[h] <= '0;
      else if (incV[h])
        halfQ[h] <= halfQ[h] + 1'b1;
    end
  end

  assign cnt = {halfQ[1], halfQ[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp    <= '1;
      ctrl   <= '0;
      status <= '0;
    end else begin
      if (wrOk && wrAddr == ADDR_CMP)  cmp  <= wrData;
      if (wrOk && wrAddr == ADDR_CTRL) ctrl <= wrData[CTRL_W-1:0];
      if (wrOk && wrAddr == ADDR_STAT)
        status <= (status & wrData[FLAG_W-1:0]) | strobe.setFlag;
      else
        status <= status | strobe.setFlag;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stopReq,
  input  logic              intTick,
  input  logic              extClk,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  cntOut,
  output logic [CNT_W-1:0]  cmpOut,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic [FLAG_W-1:0] statusOut
);
  tmrStrobe_t strobe;

  match_timer_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst_n(rst_n), .stopReq(stopReq), .intTick(intTick),
    .extClk(extClk), .cnt(cntOut), .cmp(cmpOut), .ctrl(ctrlOut),
    .strobe(strobe)
  );

  match_timer_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst_n(rst_n), .stopReq(stopReq), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .strobe(strobe),
    .cnt(cntOut), .cmp(cmpOut), .ctrl(ctrlOut), .status(statusOut)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
  import match_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stopReq,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic [CNT_W-1:0]  cntOut,
  input logic [CNT_W-1:0]  cmpOut,
  input logic [CTRL_W-1:0] ctrlOut,
  input logic [FLAG_W-1:0] statusOut
);
  a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stopReq |=> ($stable(cntOut) && $stable(cmpOut) && $stable(ctrlOut) && $stable(statusOut)));

  a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && wrAddr == ADDR_STAT) |=> ((statusOut & $past(statusOut)) == $past(statusOut)));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && !ctrlOut[C_SPLIT]) |=>
      (cntOut == $past(cntOut) || cntOut == $past(cntOut) + 1'b1 || cntOut == '0));

  a_r3_overflow_from_max: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(statusOut[F_OVF_HI]) && !$past(ctrlOut[C_SPLIT])) |-> ($past(cntOut) == '1));

  a_r4_match_on_leave: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(statusOut[F_MAT_HI]) && !$past(ctrlOut[C_SPLIT])) |-> ($past(cntOut) == $past(cmpOut)));
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rst_n(rst_n), .stopReq(stopReq), .wrEn(wrEn), .wrAddr(wrAddr),
  .cntOut(cntOut), .cmpOut(cmpOut), .ctrlOut(ctrlOut), .statusOut(statusOut)
);

// File: tb/tb_match_timer.sv
module tb_match_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stopReq = 1'b0, intTick = 1'b0, extClk = 1'b0, wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] cntOut, cmpOut;
  logic [3:0]  ctrlOut, statusOut;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  match_timer dut (
    .clk(clk), .rst_n(rst_n), .stopReq(stopReq), .intTick(intTick), .extClk(extClk),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .cntOut(cntOut), .cmpOut(cmpOut),
    .ctrlOut(ctrlOut), .statusOut(statusOut)
  );

  // {tick, expected count, expected status}
  localparam logic [20:0] VEC [0:5] = '{
    {1'b1, 16'h0011, 4'h0},
    {1'b0, 16'h0011, 4'h0},
    {1'b1, 16'h0012, 4'h0},
    {1'b0, 16'h0012, 4'h0},
    {1'b1, 16'h0013, 4'h4},
    {1'b1, 16'h0014, 4'h4}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic step(input logic t);
    intTick = t;
    @(negedge clk);
    intTick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", cntOut, 16'h0000);
    chk("R1 compare", cmpOut, 16'hFFFF);
    chk("R1 ctrl", {12'h0, ctrlOut}, 16'h0);
    chk("R1 status", {12'h0, statusOut}, 16'h0);

    // R2 / R4 vector walk around compare 0x0012
    wr(2'd1, 16'h0012);
    wr(2'd0, 16'h0010);
    for (int i = 0; i < 6; i++) begin
      step(VEC[i][20]);
      chk("R2 vector count", cntOut, VEC[i][19:4]);
      chk("R4 vector status", {12'h0, statusOut}, {12'h0, VEC[i][3:0]});
    end

    // R5 clear on match
    wr(2'd3, 16'h0);
    wr(2'd1, 16'h0005);
    wr(2'd0, 16'h0005);
    wr(2'd2, 16'h0001);
    step(1'b1);
    chk("R5 cleared count", cntOut, 16'h0000);
    chk("R5 match flag", {12'h0, statusOut}, 16'h4);

    // R3 16-bit overflow
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h1234);
    wr(2'd3, 16'h0);
    wr(2'd0, 16'hFFFF);
    step(1'b1);
    chk("R3 wrap count", cntOut, 16'h0000);
    chk("R3 overflow flag", {12'h0, statusOut}, 16'h1);

    // R8 sticky and clear
    wr(2'd3, 16'h000F);
    chk("R8 write ones keeps", {12'h0, statusOut}, 16'h1);
    wr(2'd3, 16'h0000);
    chk("R8 write zero clears", {12'h0, statusOut}, 16'h0);
    wr(2'd0, 16'h1234);
    intTick = 1'b1; wrEn = 1'b1; wrAddr = 2'd3; wrData = 16'h0;
    @(negedge clk);
    intTick = 1'b0; wrEn = 1'b0;
    chk("R8 set beats clear", {12'h0, statusOut}, 16'h4);

    // R6 / R7 split, no cascade
    wr(2'd3, 16'h0);
    wr(2'd1, 16'h3005);
    wr(2'd2, 16'h0002);
    wr(2'd0, 16'h30FF);
    step(1'b1);
    chk("R7 independent halves", cntOut, 16'h3100);
    chk("R6 low ovf and high match", {12'h0, statusOut}, 16'h6);
    wr(2'd3, 16'h0);
    wr(2'd2, 16'h0003);
    wr(2'd0, 16'h4005);
    step(1'b1);
    chk("R6 low half clears on match", cntOut, 16'h4100);
    chk("R6 low match flag", {12'h0, statusOut}, 16'h8);

    // R7 cascade
    wr(2'd3, 16'h0);
    wr(2'd2, 16'h0006);
    wr(2'd0, 16'h12FE);
    step(1'b1);
    chk("R7 high held", cntOut, 16'h12FF);
    step(1'b1);
    chk("R7 carry", cntOut, 16'h1300);
    chk("R7 low ovf flag", {12'h0, statusOut}, 16'h2);

    // R9 external source
    wr(2'd2, 16'h0008);
    wr(2'd0, 16'h0000);
    step(1'b1);
    chk("R9 intTick ignored", cntOut, 16'h0000);
    extClk = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 one edge counted", cntOut, 16'h0001);
    repeat (6) @(negedge clk);
    chk("R9 level not counted", cntOut, 16'h0001);
    extClk = 1'b0;
    repeat (3) @(negedge clk);
    extClk = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 second edge", cntOut, 16'h0002);
    extClk = 1'b0;

    // R10 module stop
    wr(2'd2, 16'h0000);
    stopReq = 1'b1;
    step(1'b1);
    chk("R10 no count", cntOut, 16'h0002);
    wr(2'd0, 16'h5555);
    chk("R10 count write ignored", cntOut, 16'h0002);
    wr(2'd2, 16'h0001);
    chk("R10 ctrl write ignored", {12'h0, ctrlOut}, 16'h0);
    stopReq = 1'b0;
    step(1'b1);
    chk("R10 resumes", cntOut, 16'h0003);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule